// File: doc/BRIEF.md
# SPI Header Phase Sequencer

This block runs one half-duplex SPI transaction as a fixed sequence of phases. An optional instruction phase, address phase, mode phase and dummy phase come first, each with its own byte count. A data phase follows: it either unpacks 32-bit words from a transmit FIFO into bytes or packs received bytes into 32-bit words for a receive FIFO. The sequencer does not toggle SPI pins itself. It hands one byte at a time to a byte-serial shifter through a valid/ready handshake. With each byte it says whether the shifter drives the data lines and how many lines the byte uses. The received byte comes back on the same handshake.

Software sets up the instruction, address and mode values, a packed header-count word, a read length, the direction, and the line-width selects. It then pulses start. A read ends by itself once the programmed number of data bytes has been received. A write keeps taking words until software raises stop, and it only ends on a word boundary. A write whose FIFO runs dry waits instead of sending filler. The busy output stays high from the cycle after an accepted start until the transaction ends.

Top module: `spi_hdr_seq`

## Requirements
- R1: The header-count word is decoded as instruction count in bits [1:0], address count in [6:4], mode count in [9:8] and dummy count in [14:12]. All other bits are ignored. The phases run in the order instruction, address, mode, dummy, data. A header phase whose count is zero sends no bytes, and each non-zero phase sends exactly its count.
- R2: Instruction, address and mode bytes are sent most significant first, taken from the low bytes of their 32-bit register. A count larger than four sends leading zero bytes.
- R3: Dummy bytes and read data bytes are offered with sh_drive low. Bytes received during the dummy phase and the header never reach rx_word. A write transaction never asserts rx_push.
- R4: In a write, each popped FIFO word is sent as exactly four bytes, least significant byte first, with sh_drive high.
- R5: In a write, tx_pop is asserted only while no word is held. If no word is available, sh_valid stays low, so the byte stream carries only FIFO data.
- R6: A read receives exactly the programmed read length of data bytes. The bytes are packed least significant first into rx_word and pushed every four bytes, and the final partial word is pushed with its unused upper bytes zero. A read length of zero ends the transaction after the header.
- R7: A write ends only when stop is high while no word is held. Stop takes priority over an available FIFO word, and a word already held is always sent in full.
- R8: sh_lanes codes are 0 for one line, 1 for two lines and 2 for four lines. Instruction and mode bytes use one line. Address bytes use four lines when cfg_addr_quad is set and one line otherwise. Dummy and data bytes follow cfg_data_width: 00 gives one line, 01 gives two, and 10 or 11 gives four.
- R9: busy rises in the cycle after an accepted start and falls when the transaction ends. A read with an all-zero header and zero length never raises busy. A start pulse while busy is ignored.
- R10: While sh_valid is high and sh_ready is low, sh_valid stays high and sh_byte holds its value.
- R11: After reset, busy, sh_valid, tx_pop and rx_push are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_instr | input | 32 | Instruction value, low bytes used |
| cfg_addr | input | 32 | Address value, low bytes used |
| cfg_mode | input | 32 | Mode value, low bytes used |
| cfg_hdr_cnt | input | 16 | Packed header phase counts |
| cfg_rd_len | input | RD_LEN_W | Read data length in bytes |
| cfg_write | input | 1 | 1 selects write, 0 selects read |
| cfg_data_width | input | 2 | Line-width select for dummy and data phases |
| cfg_addr_quad | input | 1 | Address phase uses four lines |
| ctl_start | input | 1 | Start pulse, taken only while idle |
| ctl_stop | input | 1 | Stop request for writes |
| busy | output | 1 | Transaction in progress |
| tx_valid | input | 1 | Transmit FIFO has a word |
| tx_word | input | WORD_W | Transmit FIFO head word |
| tx_pop | output | 1 | Take the transmit head word |
| rx_push | output | 1 | rx_word is valid for the receive FIFO |
| rx_word | output | WORD_W | Packed receive word |
| sh_valid | output | 1 | Byte offered to the shifter |
| sh_ready | input | 1 | Shifter completes the offered byte |
| sh_byte | output | 8 | Byte to shift out |
| sh_drive | output | 1 | Shifter drives the data lines |
| sh_lanes | output | 2 | Line-count code for the byte |
| sh_rdata | input | 8 | Byte received with the handshake |

## Verification
The bench builds the block with RD_LEN_W set to 6 and WORD_W left at 32. This puts the largest read length, 63 bytes and so sixteen pushes with a partial final word, within a short run. Random header-count words reach every field value, including instruction and mode counts of three and address and dummy counts of seven. Random shifter stalls and FIFO gaps exercise byte holding and write pauses.

// File: rtl/spi_hps_pkg.sv
// Package: shared phase type, header-count layout and line-width codes.
// Assumes: header counts are at most 3 bits wide.
package spi_hps_pkg;

    localparam int HIDX_W = 3;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_INST  = 3'd1,
        PH_ADDR  = 3'd2,
        PH_MODE  = 3'd3,
        PH_DUMMY = 3'd4,
        PH_DATA  = 3'd5
    } phase_t;

    localparam logic [1:0] LN_X1 = 2'd0;
    localparam logic [1:0] LN_X2 = 2'd1;
    localparam logic [1:0] LN_X4 = 2'd2;

    typedef struct packed {
        logic [1:0] ins;
        logic [2:0] adr;
        logic [1:0] mde;
        logic [2:0] dmy;
    } hdr_cnt_t;

    // Pull the four phase counts out of the packed count word.
    function automatic hdr_cnt_t unpack_cnt(input logic [15:0] w);
        hdr_cnt_t c;
        c.ins = w[1:0];
        c.adr = w[6:4];
        c.mde = w[9:8];
        c.dmy = w[14:12];
        return c;
    endfunction

    // Map the two-bit width select to a line-count code.
    function automatic logic [1:0] width_code(input logic [1:0] sel);
        case (sel)
            2'b00:   return LN_X1;
            2'b01:   return LN_X2;
            default: return LN_X4;
        endcase
    endfunction

endpackage

// File: rtl/hps_hdr_pick.sv
// Module: hps_hdr_pick
// Chooses the header byte for the current phase and byte index: most
// significant first out of the low bytes of the phase register, with
// zero bytes for positions beyond the register. Also returns the index
// of the last byte of the phase.
// Assumes: idx never exceeds last_idx while a header phase is active.
module hps_hdr_pick
    import spi_hps_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  phase_t             phase,
    input  logic [HIDX_W-1:0]  idx,
    input  hdr_cnt_t           cnt,
    input  logic [REG_W-1:0]   instr,
    input  logic [REG_W-1:0]   addr,
    input  logic [REG_W-1:0]   mode,
    output logic [7:0]         hbyte,
    output logic [HIDX_W-1:0]  last_idx
);

    logic [HIDX_W-1:0] n;
    logic [HIDX_W-1:0] pos;
    logic [REG_W-1:0]  src;

    // Select the count and source register of the active phase.
    always_comb begin
        case (phase)
            PH_INST:  begin n = {1'b0, cnt.ins}; src = instr; end
            PH_ADDR:  begin n = cnt.adr;         src = addr;  end
            PH_MODE:  begin n = {1'b0, cnt.mde}; src = mode;  end
            PH_DUMMY: begin n = cnt.dmy;         src = '0;    end
            default:  begin n = '0;              src = '0;    end
        endcase
    end

    // Byte position counted from the least significant end.
    always_comb begin
        pos      = n - HIDX_W'(1) - idx;
        last_idx = n - HIDX_W'(1);
        hbyte    = 8'(src >> {pos, 3'b000});
    end

endmodule

// File: rtl/hps_tx_hold.sv
// Module: hps_tx_hold
// Holds one transmit word and hands it out a byte at a time, least
// significant byte first. It frees itself after the last byte.
// Assumes: load is asserted only while have is low.
module hps_tx_hold #(
    parameter int WORD_W = 32,
    localparam int NB = WORD_W / 8,
    localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    input  logic              adv,
    output logic              have,
    output logic [7:0]        tbyte
);

    logic [WORD_W-1:0] word;
    logic [LW-1:0]     lane;

    // Load a word, then step through its bytes as the shifter takes them.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            word <= '0;
            lane <= '0;
            have <= 1'b0;
        end else if (load) begin
            word <= din;
            lane <= '0;
            have <= 1'b1;
        end else if (adv && have) begin
            lane <= lane + LW'(1);
            if (lane == LW'(NB - 1)) have <= 1'b0;
        end
    end

    // Current outgoing byte.
    always_comb tbyte = word[lane*8 +: 8];

    p_load_when_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !have);

endmodule

// File: rtl/hps_rx_pack.sv
// Module: hps_rx_pack
// Packs received bytes least significant first into a word. It pushes
// after the last lane or the final byte of the read, with the bytes not
// filled left at zero.
// Assumes: clr is pulsed at the start of every transaction.
module hps_rx_pack #(
    parameter int WORD_W = 32,
    localparam int NB = WORD_W / 8,
    localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bvld,
    input  logic [7:0]        bin,
    input  logic              last,
    output logic              push,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] merged;
    logic [LW-1:0]     lane;

    // Accumulator with the incoming byte dropped into its lane.
    always_comb begin
        merged = acc;
        merged[lane*8 +: 8] = bin;
    end

    // Collect bytes and emit a word at a lane wrap or at the end of the read.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc  <= '0;
            lane <= '0;
            push <= 1'b0;
            word <= '0;
        end else begin
            push <= 1'b0;
            if (bvld) begin
                if (lane == LW'(NB - 1) || last) begin
                    word <= merged;
                    push <= 1'b1;
                    acc  <= '0;
                    lane <= '0;
                end else begin
                    acc  <= merged;
                    lane <= lane + LW'(1);
                end
            end
        end
    end

    p_lane_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> lane == '0);

endmodule

// File: rtl/spi_hdr_seq.sv
// Module: spi_hdr_seq
// Sequences one half-duplex SPI transaction through instruction,
// address, mode, dummy and data phases. It offers bytes to a byte-serial
// shifter. Counts, direction and widths are latched at start. The
// instruction, address and mode registers are read live and must stay
// steady while busy.
module spi_hdr_seq
    import spi_hps_pkg::*;
#(
    parameter int RD_LEN_W = 16,
    parameter int WORD_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         cfg_instr,
    input  logic [31:0]         cfg_addr,
    input  logic [31:0]         cfg_mode,
    input  logic [15:0]         cfg_hdr_cnt,
    input  logic [RD_LEN_W-1:0] cfg_rd_len,
    input  logic                cfg_write,
    input  logic [1:0]          cfg_data_width,
    input  logic                cfg_addr_quad,
    input  logic                ctl_start,
    input  logic                ctl_stop,
    output logic                busy,
    input  logic                tx_valid,
    input  logic [WORD_W-1:0]   tx_word,
    output logic                tx_pop,
    output logic                rx_push,
    output logic [WORD_W-1:0]   rx_word,
    output logic                sh_valid,
    input  logic                sh_ready,
    output logic [7:0]          sh_byte,
    output logic                sh_drive,
    output logic [1:0]          sh_lanes,
    input  logic [7:0]          sh_rdata
);

    phase_t              phase;
    logic [HIDX_W-1:0]   idx;
    hdr_cnt_t            cnt_q;
    hdr_cnt_t            cnt_in;
    logic                wr_q;
    logic                aq_q;
    logic [1:0]          wd_q;
    logic [RD_LEN_W-1:0] rd_left;

    logic                in_hdr;
    logic                in_data;
    logic                fire;
    logic                start_go;
    logic [7:0]          hbyte;
    logic [HIDX_W-1:0]   last_idx;
    logic                tx_have;
    logic [7:0]          tbyte;
    logic                unused_hdr_bits;

    // Next non-empty phase after 'from'; data only if it has work to do.
    function automatic phase_t advance(input phase_t from, input hdr_cnt_t c,
                                       input logic wr, input logic rd_zero);
        if (from < PH_INST  && c.ins != '0) return PH_INST;
        if (from < PH_ADDR  && c.adr != '0) return PH_ADDR;
        if (from < PH_MODE  && c.mde != '0) return PH_MODE;
        if (from < PH_DUMMY && c.dmy != '0) return PH_DUMMY;
        if (from < PH_DATA  && (wr || !rd_zero)) return PH_DATA;
        return PH_IDLE;
    endfunction

    // Decode the count word and the phase-level strobes.
    always_comb begin
        cnt_in          = unpack_cnt(cfg_hdr_cnt);
        unused_hdr_bits = ^{cfg_hdr_cnt[15], cfg_hdr_cnt[11:10],
                            cfg_hdr_cnt[7], cfg_hdr_cnt[3:2]};
        in_hdr   = phase inside {PH_INST, PH_ADDR, PH_MODE, PH_DUMMY};
        in_data  = (phase == PH_DATA);
        busy     = (phase != PH_IDLE);
        start_go = (phase == PH_IDLE) && ctl_start;
    end

    hps_hdr_pick #(.REG_W(32)) u_pick (
        .phase    (phase),
        .idx      (idx),
        .cnt      (cnt_q),
        .instr    (cfg_instr),
        .addr     (cfg_addr),
        .mode     (cfg_mode),
        .hbyte    (hbyte),
        .last_idx (last_idx)
    );

    hps_tx_hold #(.WORD_W(WORD_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_go),
        .load  (tx_pop),
        .din   (tx_word),
        .adv   (fire && in_data && wr_q),
        .have  (tx_have),
        .tbyte (tbyte)
    );

    hps_rx_pack #(.WORD_W(WORD_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_go),
        .bvld  (fire && in_data && !wr_q),
        .bin   (sh_rdata),
        .last  (rd_left == RD_LEN_W'(1)),
        .push  (rx_push),
        .word  (rx_word)
    );

    // Shifter-side byte offer, direction and line count.
    always_comb begin
        sh_valid = in_hdr || (in_data && (!wr_q || tx_have));
        fire     = sh_valid && sh_ready;
        tx_pop   = in_data && wr_q && !tx_have && !ctl_stop && tx_valid;
        sh_drive = (phase inside {PH_INST, PH_ADDR, PH_MODE}) || (in_data && wr_q);
        if (in_data)                sh_byte = wr_q ? tbyte : 8'h00;
        else if (phase == PH_DUMMY) sh_byte = 8'h00;
        else                        sh_byte = hbyte;
        case (phase)
            PH_ADDR:           sh_lanes = aq_q ? LN_X4 : LN_X1;
            PH_DUMMY, PH_DATA: sh_lanes = width_code(wd_q);
            default:           sh_lanes = LN_X1;
        endcase
    end

    // Phase sequencer: latch setup at start, walk the phases, end on count or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            idx     <= '0;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            aq_q    <= 1'b0;
            wd_q    <= 2'b00;
            rd_left <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (ctl_start) begin
                    cnt_q   <= cnt_in;
                    wr_q    <= cfg_write;
                    aq_q    <= cfg_addr_quad;
                    wd_q    <= cfg_data_width;
                    rd_left <= cfg_rd_len;
                    idx     <= '0;
                    phase   <= advance(PH_IDLE, cnt_in, cfg_write, cfg_rd_len == '0);
                end
                PH_INST, PH_ADDR, PH_MODE, PH_DUMMY: if (fire) begin
                    if (idx == last_idx) begin
                        idx   <= '0;
                        phase <= advance(phase, cnt_q, wr_q, rd_left == '0);
                    end else begin
                        idx <= idx + HIDX_W'(1);
                    end
                end
                PH_DATA: begin
                    if (wr_q) begin
                        if (!tx_have && ctl_stop) phase <= PH_IDLE;
                    end else if (fire) begin
                        rd_left <= rd_left - RD_LEN_W'(1);
                        if (rd_left == RD_LEN_W'(1)) phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    p_idx_in_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_hdr |-> idx <= last_idx);

    p_read_has_bytes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !wr_q) |-> rd_left != '0);

    p_write_ends_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && wr_q) |-> $past(ctl_stop));

    p_byte_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_valid && !sh_ready) |=> (sh_valid && $stable(sh_byte)));

    p_no_push_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> !rx_push);

endmodule

// File: tb/tb_spi_hdr_seq.sv
module tb_spi_hdr_seq;

    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   cfg_instr = '0, cfg_addr = '0, cfg_mode = '0;
    logic [15:0]   cfg_hdr_cnt = '0;
    logic [CW-1:0] cfg_rd_len = '0;
    logic          cfg_write = 1'b0, cfg_addr_quad = 1'b0;
    logic [1:0]    cfg_data_width = 2'b00;
    logic          ctl_start = 1'b0, ctl_stop = 1'b0;
    logic          busy, tx_pop, rx_push, sh_valid, sh_drive;
    logic          tx_valid = 1'b0, sh_ready = 1'b0;
    logic [31:0]   tx_word = '0, rx_word;
    logic [7:0]    sh_byte, sh_rdata = '0;
    logic [1:0]    sh_lanes;

    always #2 clk = ~clk;

    spi_hdr_seq #(.RD_LEN_W(CW), .WORD_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_instr(cfg_instr), .cfg_addr(cfg_addr),
        .cfg_mode(cfg_mode), .cfg_hdr_cnt(cfg_hdr_cnt), .cfg_rd_len(cfg_rd_len),
        .cfg_write(cfg_write), .cfg_data_width(cfg_data_width),
        .cfg_addr_quad(cfg_addr_quad), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
        .busy(busy), .tx_valid(tx_valid), .tx_word(tx_word), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word), .sh_valid(sh_valid),
        .sh_ready(sh_ready), .sh_byte(sh_byte), .sh_drive(sh_drive),
        .sh_lanes(sh_lanes), .sh_rdata(sh_rdata)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [7:0]  exp_b[$];
    bit          exp_d[$];
    logic [1:0]  exp_l[$];
    logic [7:0]  rxb[$];
    logic [31:0] got_rx[$];
    logic [31:0] tx_q[$];
    int hdr_len = 0, hs_cnt = 0, pops = 0;
    bit cur_wr = 1'b0, hold_pend = 1'b0;
    logic [7:0] hold_b = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_all();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [1:0] wcode(input logic [1:0] s);
        return (s == 2'b00) ? 2'd0 : (s == 2'b01) ? 2'd1 : 2'd2;
    endfunction

    function automatic void add_hdr(input logic [31:0] src, input int n,
                                    input logic [1:0] ln);
        for (int i = 0; i < n; i++) begin
            exp_b.push_back(8'(64'(src) >> (8 * (n - 1 - i))));
            exp_d.push_back(1'b1);
            exp_l.push_back(ln);
        end
    endfunction

    // Shifter and transmit FIFO models, driven just after each rising edge.
    always begin
        @(posedge clk);
        #1;
        sh_ready = (($urandom % 4) != 0) && (($urandom % 16) != 0);
        sh_rdata = 8'($urandom);
        if (tx_q.size() > 0 && ($urandom % 3) != 0) begin
            tx_valid = 1'b1;
            tx_word  = tx_q[0];
        end else begin
            tx_valid = 1'b0;
        end
    end

    // Monitor on the falling edge: handshakes, holds, pops, pushes, watchdog.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_all();
        end
        if (rst_n) begin
            if (hold_pend)
                chk(sh_valid && sh_byte == hold_b, "R10 held byte",
                    {sh_valid, sh_byte}, {1'b1, hold_b});
            hold_pend = sh_valid && !sh_ready;
            hold_b    = sh_byte;
            if (sh_valid && sh_ready) begin
                if (hs_cnt < exp_b.size()) begin
                    if (exp_d[hs_cnt])
                        chk(sh_byte == exp_b[hs_cnt],
                            (hs_cnt < hdr_len) ? "R2 header byte" : "R4 R5 write byte",
                            sh_byte, exp_b[hs_cnt]);
                    chk(sh_drive == exp_d[hs_cnt], "R3 drive", sh_drive, exp_d[hs_cnt]);
                    chk(sh_lanes == exp_l[hs_cnt], "R8 lanes", sh_lanes, exp_l[hs_cnt]);
                end else begin
                    chk(1'b0, "R1 extra byte", hs_cnt, exp_b.size());
                end
                if (!cur_wr && hs_cnt >= hdr_len) rxb.push_back(sh_rdata);
                hs_cnt++;
            end
            if (tx_pop) begin
                if (tx_q.size() > 0) void'(tx_q.pop_front());
                pops++;
            end
            if (rx_push) got_rx.push_back(rx_word);
        end
    end

    task automatic run_txn(input logic [31:0] ins, input logic [31:0] ad,
                           input logic [31:0] md, input logic [15:0] hc,
                           input int rl, input bit wr, input logic [1:0] wd,
                           input bit aq, input int nw, input bit early,
                           input bit poke);
        logic [31:0] words[$];
        int nw_eff, guard, nwords;
        bit exp_busy;
        logic [31:0] ew;
        cfg_instr = ins; cfg_addr = ad; cfg_mode = md; cfg_hdr_cnt = hc;
        cfg_rd_len = CW'(rl); cfg_write = wr; cfg_data_width = wd; cfg_addr_quad = aq;
        exp_b.delete(); exp_d.delete(); exp_l.delete(); rxb.delete(); got_rx.delete();
        add_hdr(ins, int'(hc[1:0]), 2'd0);
        add_hdr(ad, int'(hc[6:4]), aq ? 2'd2 : 2'd0);
        add_hdr(md, int'(hc[9:8]), 2'd0);
        for (int i = 0; i < int'(hc[14:12]); i++) begin
            exp_b.push_back(8'h00); exp_d.push_back(1'b0); exp_l.push_back(wcode(wd));
        end
        hdr_len = exp_b.size();
        nw_eff = early ? 1 : nw;
        for (int w = 0; w < nw; w++) words.push_back($urandom);
        if (wr) begin
            for (int w = 0; w < nw_eff; w++)
                for (int b = 0; b < 4; b++) begin
                    exp_b.push_back(8'(words[w] >> (8 * b)));
                    exp_d.push_back(1'b1); exp_l.push_back(wcode(wd));
                end
        end else begin
            for (int i = 0; i < rl; i++) begin
                exp_b.push_back(8'h00); exp_d.push_back(1'b0); exp_l.push_back(wcode(wd));
            end
        end
        exp_busy = wr || hdr_len != 0 || rl != 0;
        hs_cnt = 0; pops = 0; cur_wr = wr;
        @(posedge clk); #1;
        if (wr) foreach (words[w]) tx_q.push_back(words[w]);
        ctl_start = 1'b1;
        @(posedge clk); #1;
        ctl_start = 1'b0;
        @(negedge clk);
        chk(busy == exp_busy, "R9 busy after start", busy, exp_busy);
        if (poke) begin
            repeat (3) @(posedge clk);
            #1 ctl_start = 1'b1;
            @(posedge clk); #1 ctl_start = 1'b0;
        end
        if (wr) begin
            guard = 0;
            while (pops < nw_eff && guard < 5000) begin @(negedge clk); guard++; end
            @(posedge clk); #1 ctl_stop = 1'b1;
        end
        guard = 0;
        while (busy && guard < 5000) begin @(negedge clk); guard++; end
        chk(!busy, "R9 busy falls", busy, 0);
        @(posedge clk); #1 ctl_stop = 1'b0;
        repeat (2) @(negedge clk);
        chk(hs_cnt == exp_b.size(), "R1 R6 byte count", hs_cnt, exp_b.size());
        if (wr) begin
            chk(pops == nw_eff, "R7 words taken", pops, nw_eff);
            chk(got_rx.size() == 0, "R3 no push in write", got_rx.size(), 0);
            tx_q.delete();
        end else begin
            nwords = (rl + 3) / 4;
            chk(got_rx.size() == nwords, "R6 push count", got_rx.size(), nwords);
            for (int w = 0; w < nwords && w < got_rx.size(); w++) begin
                ew = '0;
                for (int b = 0; b < 4; b++)
                    if (4 * w + b < rxb.size()) ew[8*b +: 8] = rxb[4*w + b];
                chk(got_rx[w] == ew, "R6 R3 packed word", got_rx[w], ew);
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!busy && !sh_valid && !tx_pop && !rx_push, "R11 reset state",
            {busy, sh_valid, tx_pop, rx_push}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        // directed corners
        run_txn(32'h11, 32'h22, 32'h33, 16'h0000, 0, 1'b1, 2'b00, 1'b0, 2, 1'b0, 1'b0);
        run_txn(32'h11, 32'h22, 32'h33, 16'h0000, 0, 1'b0, 2'b00, 1'b0, 0, 1'b0, 1'b0);
        run_txn(32'hA1B2C3, 32'h0DEAD5, 32'h77, 16'h2032, 5, 1'b0, 2'b01, 1'b1, 0, 1'b0, 1'b0);
        run_txn(32'h9C, 32'hCAFEF00D, 32'h5A, 16'h1153, 0, 1'b1, 2'b11, 1'b1, 1, 1'b0, 1'b0);
        run_txn(32'h03, 32'h0, 32'h0, 16'h0001, 63, 1'b0, 2'b10, 1'b0, 0, 1'b0, 1'b0);
        run_txn(32'h02, 32'h123456, 32'h0, 16'h0031, 0, 1'b1, 2'b00, 1'b0, 3, 1'b1, 1'b0);
        run_txn(32'h0B, 32'h89ABCD, 32'hE5, 16'h1131, 7, 1'b0, 2'b01, 1'b0, 0, 1'b0, 1'b1);
        run_txn(32'hFEDCBA, 32'h87654321, 32'h13579B, 16'hFFFF, 0, 1'b1, 2'b10, 1'b0, 1, 1'b0, 1'b1);
        // constrained random mix
        for (int t = 0; t < 24; t++) begin
            bit wr, early;
            int nw;
            wr = 1'($urandom % 2);
            nw = $urandom % 4;
            early = wr && nw >= 2 && ($urandom % 3) == 0;
            run_txn($urandom, $urandom, $urandom, 16'($urandom), $urandom % 14, wr,
                    2'($urandom), 1'($urandom), nw, early, ($urandom % 4) == 0);
        end
        finish_all();
    end

endmodule